// File: doc/BRIEF.md
# Free-Running Timer with Software Compare Channel

This block is a memory-mapped up-counter for system timekeeping and one-shot event generation. A 32-bit count register advances once per prescaled tick, where the prescaler divides the core clock by a power of two between 1 and 128. The count restarts from zero after it reaches a programmable wrap limit, and each such wrap sets a sticky overflow flag. With the wrap limit left at its reset value of all ones, the count runs through its whole range and acts as a clock source that software can read.

One compare channel watches the count. In its software-compare mode it raises a sticky event flag on the edge where the count steps onto the programmed compare value. It then drives a level interrupt if its enable bit is set. To schedule an event, software reads the count, adds a delay, writes the sum into the compare register, and later clears the flag from either of two places: the channel register or a shared event-status register. A compare value that the count has already passed matches only after the count wraps around and reaches it again.

Software reaches the registers through a single-beat word bus. A request cycle with select high performs any write on that clock edge. Ready and read data follow one cycle later.

Top module: `cmp_timer`

## Requirements
- R1: After reset the registers read as follows. Control, count, event status, channel control and compare all read 0. The wrap limit reads 0xFFFFFFFF. `irq` and `bus_ready` are low.
- R2: For a request in the cycle with `bus_sel` high, `bus_ready` is high in the next cycle and low after any cycle without a request. A read returns its data with ready. Registers sit at byte offsets 0x10 (control), 0x14 (count), 0x18 (wrap limit), 0x1C (event status), 0x20 (channel control) and 0x24 (compare). Any other offset reads 0.
- R3: Control bits 4:3 hold the clock mode. Only the value 1 makes the count run; any other value holds it. Control bits 2:0 hold `p`, and the count advances once every 2^p clocks. The first step lands 2^p clocks after the edge that started the count.
- R4: A write of any value to the count register sets the count to 0 and restarts the prescaler on that edge. This write takes priority over a tick.
- R5: When a tick finds the count equal to the wrap limit, the count becomes 0 and control bit 7 (overflow) sets on the same edge. Writing 1 to control bit 7 clears it; writing 0 leaves it.
- R6: With the wrap limit at its reset value, the count keeps climbing and does not wrap or flag overflow at small values.
- R7: Channel control bits 5:2 hold the mode, bit 6 the interrupt enable and bit 7 the event flag. In mode 4 the flag sets on the edge where the count steps onto the compare value. Writing 1 to bit 7 clears it.
- R8: A compare value that lies below the current count produces no event until the count wraps and reaches that value again.
- R9: `irq` is high exactly while the event flag and the interrupt enable are both set. Setting the enable while the flag is pending raises `irq`.
- R10: Event-status bit 0 reads as the channel event flag. Writing 1 to that bit clears the same flag.
- R11: In any channel mode other than 4 the event flag never sets. A flag that is already set stays set when the mode changes.
- R12: When a set condition and a write-one-to-clear for the same flag (overflow or channel event) fall on one edge, the flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Request valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ready` |
| bus_ready | output | 1 | Request completed, one cycle after `bus_sel` |
| irq | output | 1 | Level interrupt from the compare channel |

## Verification
Register writes act on the edge of the request cycle. A read captures the register value from before its own edge and shows it in the following cycle. If a run is started at edge E and the bench waits n idle cycles, the next read reports the count after edge E+n, which is floor(n / 2^p). Flags and `irq` change on the same edge as the count step that causes them, so the bench samples `irq` at the falling edge right after the predicted step and checks the cycle before it as well. Set-versus-clear collisions are produced by landing a clearing write on the exact edge where a wrap is predicted.

// File: rtl/timer_pkg.sv
package timer_pkg;

    localparam int unsigned REG_W = 32;
    localparam int unsigned PSC_W = 3;
    localparam int unsigned DIV_W = (1 << PSC_W) - 1;

    localparam logic [7:0] OFS_CTRL   = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_LIMIT  = 8'h18;
    localparam logic [7:0] OFS_EVSTAT = 8'h1C;
    localparam logic [7:0] OFS_CH0CTL = 8'h20;
    localparam logic [7:0] OFS_CH0CMP = 8'h24;

    localparam int unsigned CM_LSB      = 3;
    localparam int unsigned OVF_BIT     = 7;
    localparam int unsigned CH_MODE_LSB = 2;
    localparam int unsigned CH_IE_BIT   = 6;
    localparam int unsigned CH_FLAG_BIT = 7;
    localparam int unsigned EV_CH0_BIT  = 0;

    localparam logic [3:0] CHM_SWCMP = 4'h4;

    typedef enum logic [1:0] {
        CM_STOP = 2'd0,
        CM_TICK = 2'd1,
        CM_RSV2 = 2'd2,
        CM_RSV3 = 2'd3
    } clk_mode_e;

    typedef struct packed {
        logic             ovf;
        clk_mode_e        cm;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

    typedef struct packed {
        logic       flag;
        logic       ie;
        logic [3:0] mode;
    } chctl_t;

    // sticky flag update: a set on the same edge beats a clear
    function automatic logic w1c_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    // low bits of the divider that must all be ones for a tick
    function automatic logic [DIV_W-1:0] psc_mask(input logic [PSC_W-1:0] psc);
        logic [DIV_W:0] one_hot;
        one_hot = (DIV_W + 1)'(1) << psc;
        return DIV_W'(one_hot - 1'b1);
    endfunction

    function automatic logic [REG_W-1:0] ctrl_word(input ctrl_t c);
        logic [REG_W-1:0] w;
        w              = '0;
        w[PSC_W-1:0]   = c.psc;
        w[CM_LSB +: 2] = c.cm;
        w[OVF_BIT]     = c.ovf;
        return w;
    endfunction

    function automatic logic [REG_W-1:0] chctl_word(input chctl_t c);
        logic [REG_W-1:0] w;
        w                   = '0;
        w[CH_MODE_LSB +: 4] = c.mode;
        w[CH_IE_BIT]        = c.ie;
        w[CH_FLAG_BIT]      = c.flag;
        return w;
    endfunction

endpackage

// File: rtl/timer_prescale.sv
module timer_prescale
    import timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    assign mask = psc_mask(psc);
    assign tick = run && !restart && ((div_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_nxt,
    output logic             advance,
    output logic             wrap
);

    assign advance = tick && !clear;
    assign wrap    = advance && (cnt_q == limit);
    assign cnt_nxt = wrap ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/timer_channel.sv
module timer_channel
    import timer_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic             cmp_wr,
    input  logic             stat_clr,
    input  logic [REG_W-1:0] wdata,
    input  logic             advance,
    input  logic [CNT_W-1:0] cnt_nxt,
    output chctl_t           ctl_q,
    output logic [CNT_W-1:0] cmp_q,
    output logic             irq
);

    logic hit;
    logic clr;

    assign hit = advance && (ctl_q.mode == CHM_SWCMP) && (cnt_nxt == cmp_q);
    assign clr = (ctl_wr && wdata[CH_FLAG_BIT]) || stat_clr;
    assign irq = ctl_q.flag && ctl_q.ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmp_q <= '0;
        end else begin
            ctl_q.flag <= w1c_next(ctl_q.flag, hit, clr);
            if (ctl_wr) begin
                ctl_q.ie   <= wdata[CH_IE_BIT];
                ctl_q.mode <= wdata[CH_MODE_LSB +: 4];
            end
            if (cmp_wr) begin
                cmp_q <= wdata[CNT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
    import timer_pkg::*;
#(
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_ready,
    output logic              irq
);

    logic acc_wr;
    logic wr_ctrl, wr_count, wr_limit, wr_evstat, wr_chctl, wr_chcmp;

    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] limit_q;
    logic             run;
    logic             tick;
    logic [CNT_W-1:0] cnt_q, cnt_nxt;
    logic             advance, wrap;
    chctl_t           ch_ctl;
    logic [CNT_W-1:0] ch_cmp;
    logic             ch_flag;
    logic [3:0]       ch_mode;
    logic [REG_W-1:0] rd_mux;
    logic [REG_W-1:0] rdata_q;
    logic             ready_q;

    assign acc_wr    = bus_sel && bus_we;
    assign wr_ctrl   = acc_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_count  = acc_wr && (bus_addr == ADDR_W'(OFS_COUNT));
    assign wr_limit  = acc_wr && (bus_addr == ADDR_W'(OFS_LIMIT));
    assign wr_evstat = acc_wr && (bus_addr == ADDR_W'(OFS_EVSTAT));
    assign wr_chctl  = acc_wr && (bus_addr == ADDR_W'(OFS_CH0CTL));
    assign wr_chcmp  = acc_wr && (bus_addr == ADDR_W'(OFS_CH0CMP));

    assign run = (ctrl_q.cm == CM_TICK);

    timer_prescale u_psc (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .restart (wr_count),
        .psc     (ctrl_q.psc),
        .tick    (tick)
    );

    timer_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .clear   (wr_count),
        .limit   (limit_q),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .advance (advance),
        .wrap    (wrap)
    );

    timer_channel #(.CNT_W(CNT_W)) u_ch0 (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (wr_chctl),
        .cmp_wr   (wr_chcmp),
        .stat_clr (wr_evstat && bus_wdata[EV_CH0_BIT]),
        .wdata    (bus_wdata),
        .advance  (advance),
        .cnt_nxt  (cnt_nxt),
        .ctl_q    (ch_ctl),
        .cmp_q    (ch_cmp),
        .irq      (irq)
    );

    assign ch_flag = ch_ctl.flag;
    assign ch_mode = ch_ctl.mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            limit_q <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.psc <= bus_wdata[PSC_W-1:0];
                ctrl_q.cm  <= clk_mode_e'(bus_wdata[CM_LSB +: 2]);
            end
            ctrl_q.ovf <= w1c_next(ctrl_q.ovf, wrap, wr_ctrl && bus_wdata[OVF_BIT]);
            if (wr_limit) begin
                limit_q <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   rd_mux = ctrl_word(ctrl_q);
            ADDR_W'(OFS_COUNT):  rd_mux = REG_W'(cnt_q);
            ADDR_W'(OFS_LIMIT):  rd_mux = REG_W'(limit_q);
            ADDR_W'(OFS_EVSTAT): rd_mux = REG_W'(ch_flag) << EV_CH0_BIT;
            ADDR_W'(OFS_CH0CTL): rd_mux = chctl_word(ch_ctl);
            ADDR_W'(OFS_CH0CMP): rd_mux = REG_W'(ch_cmp);
            default:             rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= bus_sel;
            if (bus_sel && !bus_we) begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/timer_cmp_checker.sv
module timer_cmp_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_ready,
    input logic             irq,
    input logic             ch_flag,
    input logic [3:0]       ch_mode,
    input logic             run,
    input logic             cnt_wr,
    input logic             tick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit,
    input logic             ovf
);

    AST_READY_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        bus_sel |=> bus_ready); // R2

    AST_READY_ONLY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> !bus_ready); // R2

    AST_HALT_HOLDS_COUNT: assert property (@(posedge clk) disable iff (rst)
        (!run && !cnt_wr) |=> $stable(cnt)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt != limit) |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R3

    AST_COUNT_WRITE_ZERO: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == '0)); // R4

    AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_wr && cnt == limit) |=> (ovf && cnt == '0)); // R5

    AST_IDLE_CHANNEL_QUIET: assert property (@(posedge clk) disable iff (rst)
        (ch_mode != 4'h4 && !ch_flag) |=> !ch_flag); // R11

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq |-> ch_flag); // R9

endmodule

bind cmp_timer timer_cmp_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_ready (bus_ready),
    .irq       (irq),
    .ch_flag   (ch_flag),
    .ch_mode   (ch_mode),
    .run       (run),
    .cnt_wr    (wr_count),
    .tick      (tick),
    .cnt       (cnt_q),
    .limit     (limit_q),
    .ovf       (ctrl_q.ovf)
);

// File: tb/sim_cmp_timer.sv
module sim_cmp_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    localparam logic [7:0] A_CTRL   = 8'h10;
    localparam logic [7:0] A_COUNT  = 8'h14;
    localparam logic [7:0] A_LIMIT  = 8'h18;
    localparam logic [7:0] A_EVSTAT = 8'h1C;
    localparam logic [7:0] A_CH0CTL = 8'h20;
    localparam logic [7:0] A_CH0CMP = 8'h24;

    // prescale select, idle cycles after start, expected count = floor(idle / 2^psc)
    localparam int NVEC = 8;
    localparam int VEC_PSC  [NVEC] = '{0, 0, 1, 2, 3, 3, 3, 7};
    localparam int VEC_IDLE [NVEC] = '{0, 5, 7, 11, 7, 8, 16, 130};
    localparam int VEC_EXP  [NVEC] = '{0, 5, 3, 2, 0, 1, 2, 1};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cmp_timer u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 ready", {31'd0, bus_ready}, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);
        bus_rd(A_CTRL, rd);   chk("R1 ctrl", rd, 32'h0);
        bus_rd(A_COUNT, rd);  chk("R1 count", rd, 32'h0);
        bus_rd(A_LIMIT, rd);  chk("R1 limit", rd, 32'hFFFF_FFFF);
        bus_rd(A_EVSTAT, rd); chk("R1 evstat", rd, 32'h0);
        bus_rd(A_CH0CTL, rd); chk("R1 ch0ctl", rd, 32'h0);
        bus_rd(A_CH0CMP, rd); chk("R1 ch0cmp", rd, 32'h0);

        // R2 handshake timing and decode
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = A_LIMIT;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0;
        chk("R2 ready after request", {31'd0, bus_ready}, 32'd1);
        @(posedge clk); @(negedge clk);
        chk("R2 ready after idle", {31'd0, bus_ready}, 32'd0);
        bus_wr(A_CH0CMP, 32'hA5A5_0001);
        bus_rd(A_CH0CMP, rd); chk("R2 compare readback", rd, 32'hA5A5_0001);
        bus_rd(8'h04, rd);    chk("R2 unmapped", rd, 32'h0);
        bus_wr(A_CH0CMP, 32'd100000);

        // R3 prescaler table
        for (int i = 0; i < NVEC; i++) begin
            bus_wr(A_CTRL, 32'h0);
            bus_wr(A_COUNT, 32'h0);
            bus_wr(A_CTRL, 32'h08 | VEC_PSC[i]);
            idle(VEC_IDLE[i]);
            bus_rd(A_COUNT, rd);
            chk($sformatf("R3 vec %0d", i), rd, VEC_EXP[i]);
        end

        // R3 reserved clock mode holds the count
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_CTRL, 32'h10);
        idle(10);
        bus_rd(A_COUNT, rd); chk("R3 mode 2 holds", rd, 32'h0);

        // R6 default limit runs freely
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_CTRL, 32'h08);
        idle(40);
        bus_rd(A_COUNT, rd); chk("R6 free count", rd, 32'd40);
        bus_rd(A_CTRL, rd);  chk("R6 no overflow", rd, 32'h08);

        // R4 count write zeroes while running
        bus_wr(A_COUNT, 32'h1234);
        bus_rd(A_COUNT, rd); chk("R4 zero after write", rd, 32'd0);
        bus_rd(A_COUNT, rd); chk("R4 resumes", rd, 32'd1);

        // R5 wrap and overflow
        bus_wr(A_CTRL, 32'h80);
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_LIMIT, 32'd3);
        bus_wr(A_CTRL, 32'h08);
        idle(3);
        bus_rd(A_CTRL, rd);  chk("R5 before wrap", rd, 32'h08);
        bus_rd(A_CTRL, rd);  chk("R5 overflow set", rd, 32'h88);
        bus_rd(A_COUNT, rd); chk("R5 count after wrap", rd, 32'd1);
        bus_wr(A_CTRL, 32'h80);
        bus_rd(A_CTRL, rd);  chk("R5 overflow cleared", rd, 32'h00);

        // R12 set beats clear on the same edge
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_CTRL, 32'h08);
        idle(3);
        bus_wr(A_CTRL, 32'h88);
        bus_rd(A_CTRL, rd);  chk("R12 overflow set wins", rd, 32'h88);
        bus_wr(A_CTRL, 32'h80);
        bus_wr(A_LIMIT, 32'hFFFF_FFFF);

        // R7 R9 R10 compare event
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_CH0CMP, 32'd5);
        bus_wr(A_CH0CTL, 32'h50);
        bus_wr(A_CTRL, 32'h08);
        idle(4);
        chk("R7 no event before match", {31'd0, irq}, 32'd0);
        idle(1);
        chk("R9 irq on match", {31'd0, irq}, 32'd1);
        bus_rd(A_CH0CTL, rd); chk("R7 flag set", rd, 32'hD0);
        bus_rd(A_EVSTAT, rd); chk("R10 mirror", rd, 32'h1);
        bus_wr(A_EVSTAT, 32'h1);
        chk("R10 clear via status", {31'd0, irq}, 32'd0);
        bus_rd(A_CH0CTL, rd); chk("R10 flag cleared", rd, 32'h50);

        // R9 enable gating
        bus_wr(A_CTRL, 32'h80);
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_CH0CTL, 32'h10);
        bus_wr(A_CTRL, 32'h08);
        idle(6);
        chk("R9 masked irq", {31'd0, irq}, 32'd0);
        bus_rd(A_CH0CTL, rd); chk("R9 flag pending", rd, 32'h90);
        bus_wr(A_CH0CTL, 32'h50);
        chk("R9 enable raises irq", {31'd0, irq}, 32'd1);
        bus_wr(A_CH0CTL, 32'hD0);
        chk("R7 clear via channel", {31'd0, irq}, 32'd0);

        // R8 passed compare waits for wrap
        bus_wr(A_CTRL, 32'h0);
        bus_wr(A_CH0CMP, 32'd100);
        bus_wr(A_COUNT, 32'h0);
        bus_wr(A_LIMIT, 32'd15);
        bus_wr(A_CTRL, 32'h08);
        idle(8);
        bus_wr(A_CH0CMP, 32'd4);
        idle(10);
        chk("R8 no early event", {31'd0, irq}, 32'd0);
        bus_rd(A_CH0CTL, rd); chk("R8 flag clear before wrap match", rd, 32'h50);
        chk("R8 event after wrap", {31'd0, irq}, 32'd1);

        // R11 mode change keeps flag, other modes stay quiet
        bus_wr(A_CH0CTL, 32'h48);
        chk("R11 flag kept", {31'd0, irq}, 32'd1);
        bus_wr(A_EVSTAT, 32'h1);
        idle(40);
        chk("R11 no irq in mode 2", {31'd0, irq}, 32'd0);
        bus_rd(A_CH0CTL, rd); chk("R11 no flag in mode 2", rd, 32'h48);
        bus_wr(A_CH0CTL, 32'h00);
        idle(40);
        bus_rd(A_CH0CTL, rd); chk("R11 disabled channel", rd, 32'h00);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule